// File: doc/BRIEF.md
# Vector Lane Insert and Broadcast Unit

This block computes the new value of one 128-bit vector register after a lane-granular move. Each cycle it takes an operation code, a lane configuration, two lane indices, a source vector, a 64-bit scalar and the current destination contents. It returns the updated destination one clock later, together with a flag that marks the request as illegal.

There are two kinds of move. An insert overwrites exactly one lane of the destination and keeps every other lane. A broadcast fills every lane of the destination with one value. For both kinds the value comes from a chosen lane of the source vector or from the low bits of the scalar.

The lane configuration picks both the lane width and whether the vector is the 64-bit form or the 128-bit form. A broadcast in the 64-bit form clears the upper half of the destination. Each scalar width is accepted only with certain configurations. An illegal request raises the flag and returns the destination unchanged.

Top module: `vlm_unit`

## Requirements
- R1: `cfg_i` encodes the lane size in bits [2:1] (0 byte, 1 halfword, 2 word, 3 doubleword) and the form in bit 0 (0 = 64-bit form, 1 = 128-bit form). This gives 0=8B, 1=16B, 2=4H, 3=8H, 4=2S, 5=4S, 6=1D, 7=2D. Lane i of width w occupies bits [(i+1)*w-1 : i*w], with lane 0 at the least-significant end.
- R2: The result is registered. `res_o` and `illegal_o` reflect the inputs of the previous clock edge. During reset both read zero.
- R3: Opcode 0 (lane-to-lane insert) copies source lane `src_idx_i` into destination lane `dst_idx_i`. All other destination bits are kept, including the upper half in the 64-bit forms. It is legal in every configuration.
- R4: Opcode 1 (narrow scalar insert) writes the low w bits of `scalar_i` into destination lane `dst_idx_i` and keeps all other bits. It is legal only for configurations 0 to 5.
- R5: Opcode 2 (wide scalar insert) writes all 64 scalar bits into lane 0 and keeps bits 127:64. It is legal only with configuration 6 (1D).
- R6: Opcode 3 (lane broadcast) copies source lane `src_idx_i` into every destination lane. In the 64-bit forms, bits 127:64 become zero.
- R7: Opcode 4 (narrow scalar broadcast) copies the low w bits of `scalar_i` into every lane. It is legal only for configurations 0 to 5, and it zeroes bits 127:64 in the 64-bit forms.
- R8: Opcode 5 (wide scalar broadcast) copies `scalar_i` into both doubleword lanes. It is legal only with configuration 7 (2D).
- R9: An index that the operation uses must be below the configuration's lane count. If it is not, or if the configuration is not accepted for the opcode, `illegal_o` rises and `res_o` equals the `dst_vec_i` that was presented.
- R10: Opcodes 6 and 7 are reserved. They always raise `illegal_o` and return `dst_vec_i` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_i | input | 3 | Operation code |
| cfg_i | input | 3 | Lane size and vector form |
| dst_idx_i | input | 4 | Destination lane index for inserts |
| src_idx_i | input | 4 | Source lane index for lane moves |
| src_vec_i | input | 128 | Source vector |
| scalar_i | input | 64 | Scalar value |
| dst_vec_i | input | 128 | Current destination contents |
| res_o | output | 128 | New destination contents |
| illegal_o | output | 1 | Request was illegal; result is the old destination |

## Verification
Directed cases start the destination with nonzero upper bits. This shows the difference between inserts, which must keep those bits, and 64-bit-form broadcasts, which must clear them. A halfword write to the top lane and a word broadcast from lane 2 show whether lane offsets and lane selection are correct.

Each scalar opcode is also tried with configurations it must reject. Indices are placed exactly at the lane count, to catch an off-by-one in the range check. Random traffic mixes every opcode with every configuration and draws indices mostly within range. This exercises the byte replication for every lane width and both vector forms.

// File: rtl/vlm_pkg.sv
package vlm_pkg;
    localparam int VEC_W      = 128;
    localparam int SCALAR_W   = 64;
    localparam int BYTE_W     = 8;
    localparam int VEC_BYTES  = VEC_W / BYTE_W;
    localparam int HALF_BYTES = VEC_BYTES / 2;
    localparam int SC_BYTES   = SCALAR_W / BYTE_W;
    localparam int IDX_W      = $clog2(VEC_BYTES);
    localparam int OFF_W      = $clog2(SC_BYTES);

    typedef enum logic [2:0] {
        OP_INS_LANE = 3'd0,
        OP_INS_W    = 3'd1,
        OP_INS_X    = 3'd2,
        OP_DUP_LANE = 3'd3,
        OP_DUP_W    = 3'd4,
        OP_DUP_X    = 3'd5,
        OP_RSV6     = 3'd6,
        OP_RSV7     = 3'd7
    } vlm_op_e;

    typedef enum logic [2:0] {
        CFG_B8  = 3'd0,
        CFG_B16 = 3'd1,
        CFG_H4  = 3'd2,
        CFG_H8  = 3'd3,
        CFG_S2  = 3'd4,
        CFG_S4  = 3'd5,
        CFG_D1  = 3'd6,
        CFG_D2  = 3'd7
    } vlm_cfg_e;

    typedef struct packed {
        logic [VEC_W-1:0] res;
        logic             illegal;
    } vlm_state_t;
endpackage

// File: rtl/vlm_legal.sv
module vlm_legal
    import vlm_pkg::*;
(
    input  logic [2:0]       op,
    input  logic [2:0]       cfg,
    input  logic [IDX_W-1:0] dst_idx,
    input  logic [IDX_W-1:0] src_idx,
    output logic             legal
);
    localparam logic [IDX_W:0] FULL_LANES = (IDX_W+1)'(VEC_BYTES);
    localparam logic [IDX_W:0] HALF_LANES = (IDX_W+1)'(HALF_BYTES);

    logic [1:0]     size;
    logic           wide;
    logic [IDX_W:0] n_lanes;
    logic           dst_ok;
    logic           src_ok;
    logic           narrow_cfg;

    always_comb begin
        size       = cfg[2:1];
        wide       = cfg[0];
        n_lanes    = (wide ? FULL_LANES : HALF_LANES) >> size;
        dst_ok     = {1'b0, dst_idx} < n_lanes;
        src_ok     = {1'b0, src_idx} < n_lanes;
        narrow_cfg = (size != 2'd3);
        case (op)
            OP_INS_LANE: legal = dst_ok && src_ok;
            OP_INS_W:    legal = narrow_cfg && dst_ok;
            OP_INS_X:    legal = (cfg == CFG_D1) && dst_ok;
            OP_DUP_LANE: legal = src_ok;
            OP_DUP_W:    legal = narrow_cfg;
            OP_DUP_X:    legal = (cfg == CFG_D2);
            default:     legal = 1'b0;
        endcase
    end
endmodule

// File: rtl/vlm_lane_pick.sv
module vlm_lane_pick
    import vlm_pkg::*;
(
    input  logic [VEC_W-1:0]    src_vec,
    input  logic [IDX_W-1:0]    src_idx,
    input  logic [SCALAR_W-1:0] scalar,
    input  logic                use_scalar,
    input  logic [1:0]          size,
    output logic [SCALAR_W-1:0] lane_val
);
    logic [VEC_BYTES-1:0][BYTE_W-1:0] src_b;
    logic [SC_BYTES-1:0][BYTE_W-1:0]  sc_b;
    logic [SC_BYTES-1:0][BYTE_W-1:0]  val_b;
    logic [OFF_W:0]                   lane_bytes;
    logic [IDX_W+OFF_W:0]             base;

    assign src_b      = src_vec;
    assign sc_b       = scalar;
    assign lane_bytes = (OFF_W+1)'(1) << size;
    assign base       = {{(OFF_W+1){1'b0}}, src_idx} << size;

    for (genvar k = 0; k < SC_BYTES; k++) begin : g_byte
        logic [IDX_W+OFF_W:0] sel;
        logic                 in_lane;
        assign sel      = base + (IDX_W+OFF_W+1)'(k);
        assign in_lane  = (OFF_W+1)'(k) < lane_bytes;
        assign val_b[k] = !in_lane   ? '0 :
                          use_scalar ? sc_b[k] : src_b[sel[IDX_W-1:0]];
    end

    assign lane_val = val_b;
endmodule

// File: rtl/vlm_lane_merge.sv
module vlm_lane_merge
    import vlm_pkg::*;
(
    input  logic [VEC_W-1:0]    dst_vec,
    input  logic [SCALAR_W-1:0] lane_val,
    input  logic [1:0]          size,
    input  logic                wide,
    input  logic                broadcast,
    input  logic [IDX_W-1:0]    dst_idx,
    output logic [VEC_W-1:0]    merged
);
    logic [VEC_BYTES-1:0][BYTE_W-1:0] dst_b;
    logic [VEC_BYTES-1:0][BYTE_W-1:0] out_b;
    logic [SC_BYTES-1:0][BYTE_W-1:0]  val_b;
    logic [OFF_W-1:0]                 off_mask;

    assign dst_b    = dst_vec;
    assign val_b    = lane_val;
    assign off_mask = OFF_W'(((OFF_W+1)'(1) << size) - (OFF_W+1)'(1));

    for (genvar b = 0; b < VEC_BYTES; b++) begin : g_byte
        localparam logic [IDX_W-1:0] BI    = IDX_W'(b);
        localparam bit               UPPER = (b >= HALF_BYTES);
        logic [OFF_W-1:0] off;
        logic [IDX_W-1:0] lane_no;
        logic             hit;
        logic [BYTE_W-1:0] rep;
        assign off      = BI[OFF_W-1:0] & off_mask;
        assign lane_no  = BI >> size;
        assign hit      = (lane_no == dst_idx);
        assign rep      = val_b[off];
        assign out_b[b] = broadcast ? ((UPPER && !wide) ? '0 : rep)
                                    : (hit ? rep : dst_b[b]);
    end

    assign merged = out_b;
endmodule

// File: rtl/vlm_unit.sv
module vlm_unit
    import vlm_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [2:0]          op_i,
    input  logic [2:0]          cfg_i,
    input  logic [IDX_W-1:0]    dst_idx_i,
    input  logic [IDX_W-1:0]    src_idx_i,
    input  logic [VEC_W-1:0]    src_vec_i,
    input  logic [SCALAR_W-1:0] scalar_i,
    input  logic [VEC_W-1:0]    dst_vec_i,
    output logic [VEC_W-1:0]    res_o,
    output logic                illegal_o
);
    logic                legal;
    logic                use_scalar;
    logic                broadcast;
    logic [SCALAR_W-1:0] lane_val;
    logic [VEC_W-1:0]    merged;
    vlm_state_t          state_d;
    vlm_state_t          state_q;

    assign use_scalar = (op_i == OP_INS_W) || (op_i == OP_INS_X) ||
                        (op_i == OP_DUP_W) || (op_i == OP_DUP_X);
    assign broadcast  = (op_i == OP_DUP_LANE) || (op_i == OP_DUP_W) ||
                        (op_i == OP_DUP_X);

    vlm_legal u_legal (
        .op      (op_i),
        .cfg     (cfg_i),
        .dst_idx (dst_idx_i),
        .src_idx (src_idx_i),
        .legal   (legal)
    );

    vlm_lane_pick u_pick (
        .src_vec    (src_vec_i),
        .src_idx    (src_idx_i),
        .scalar     (scalar_i),
        .use_scalar (use_scalar),
        .size       (cfg_i[2:1]),
        .lane_val   (lane_val)
    );

    vlm_lane_merge u_merge (
        .dst_vec   (dst_vec_i),
        .lane_val  (lane_val),
        .size      (cfg_i[2:1]),
        .wide      (cfg_i[0]),
        .broadcast (broadcast),
        .dst_idx   (dst_idx_i),
        .merged    (merged)
    );

    always_comb begin
        state_d         = state_q;
        state_d.illegal = !legal;
        state_d.res     = legal ? merged : dst_vec_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign res_o     = state_q.res;
    assign illegal_o = state_q.illegal;

    // R10
    rsv_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_RSV6 || op_i == OP_RSV7) |=> illegal_o);

    // R5
    ins_x_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_INS_X && cfg_i != CFG_D1) |=> illegal_o);

    // R8
    dup_x_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_DUP_X && cfg_i != CFG_D2) |=> illegal_o);

    // R4
    narrow_sc_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((op_i == OP_INS_W || op_i == OP_DUP_W) && cfg_i[2:1] == 2'd3) |=> illegal_o);

    // R9
    keep_on_illegal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> (res_o == $past(dst_vec_i)));

    // R3
    ins_upper_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((op_i == OP_INS_LANE || op_i == OP_INS_W || op_i == OP_INS_X) && !cfg_i[0])
        |=> (res_o[VEC_W-1:VEC_W/2] == $past(dst_vec_i[VEC_W-1:VEC_W/2])));

    // R6
    dup_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((op_i == OP_DUP_LANE || op_i == OP_DUP_W || op_i == OP_DUP_X) && !cfg_i[0])
        |=> (illegal_o || res_o[VEC_W-1:VEC_W/2] == '0));
endmodule

// File: tb/vlm_unit_bench.sv
module vlm_unit_bench;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [2:0]   op_i = '0;
    logic [2:0]   cfg_i = '0;
    logic [3:0]   dst_idx_i = '0;
    logic [3:0]   src_idx_i = '0;
    logic [127:0] src_vec_i = '0;
    logic [63:0]  scalar_i = '0;
    logic [127:0] dst_vec_i = '0;
    logic [127:0] res_o;
    logic         illegal_o;

    int compared = 0;
    int mismatched = 0;
    bit done = 0;

    always #4 clk = ~clk;

    vlm_unit u_vlm_unit (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_i      (op_i),
        .cfg_i     (cfg_i),
        .dst_idx_i (dst_idx_i),
        .src_idx_i (src_idx_i),
        .src_vec_i (src_vec_i),
        .scalar_i  (scalar_i),
        .dst_vec_i (dst_vec_i),
        .res_o     (res_o),
        .illegal_o (illegal_o)
    );

    function automatic int lanes_of(input logic [2:0] cfg);
        int w = 8 << cfg[2:1];
        return (cfg[0] ? 128 : 64) / w;
    endfunction

    function automatic logic [128:0] model(input logic [2:0] op, input logic [2:0] cfg,
                                           input logic [3:0] di, input logic [3:0] si,
                                           input logic [127:0] src, input logic [63:0] sc,
                                           input logic [127:0] dst);
        int w = 8 << cfg[2:1];
        int n = lanes_of(cfg);
        bit ok;
        logic [63:0]  v;
        logic [127:0] r;
        case (op)
            3'd0: ok = (int'(di) < n) && (int'(si) < n);
            3'd1: ok = (cfg <= 3'd5) && (int'(di) < n);
            3'd2: ok = (cfg == 3'd6) && (int'(di) < n);
            3'd3: ok = (int'(si) < n);
            3'd4: ok = (cfg <= 3'd5);
            3'd5: ok = (cfg == 3'd7);
            default: ok = 0;
        endcase
        if (!ok) return {1'b1, dst};
        v = '0;
        for (int b = 0; b < w; b++)
            v[b] = (op == 3'd0 || op == 3'd3) ? src[int'(si)*w + b] : sc[b];
        if (op <= 3'd2) begin
            r = dst;
            for (int b = 0; b < w; b++) r[int'(di)*w + b] = v[b];
        end else begin
            r = '0;
            for (int l = 0; l < n; l++)
                for (int b = 0; b < w; b++) r[l*w + b] = v[b];
        end
        return {1'b0, r};
    endfunction

    function automatic string tag_of(input logic [2:0] op, input logic ill);
        if (op >= 3'd6) return "R10";
        if (ill) return "R9";
        case (op)
            3'd0: return "R3";
            3'd1: return "R4";
            3'd2: return "R5";
            3'd3: return "R6";
            3'd4: return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic check(input string req, input logic [128:0] exp);
        compared++;
        if ({illegal_o, res_o} !== exp) begin
            mismatched++;
            $display("FAIL %s: got ill=%0b res=%h, expected ill=%0b res=%h",
                     req, illegal_o, res_o, exp[128], exp[127:0]);
        end
    endtask

    task automatic run_op(input logic [2:0] op, input logic [2:0] cfg,
                          input logic [3:0] di, input logic [3:0] si,
                          input logic [127:0] src, input logic [63:0] sc,
                          input logic [127:0] dst, input string req);
        logic [128:0] exp;
        @(negedge clk);
        op_i = op; cfg_i = cfg; dst_idx_i = di; src_idx_i = si;
        src_vec_i = src; scalar_i = sc; dst_vec_i = dst;
        exp = model(op, cfg, di, si, src, sc, dst);
        @(posedge clk);
        #2;
        check((req == "") ? tag_of(op, exp[128]) : req, exp);
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        logic [127:0] pat;
        logic [127:0] v10;
        pat = {4{32'h40100401}};
        v10 = {32'h3344AABB, 32'h3344AABB, 32'h00091A1A, 32'h00091A1A};
        repeat (3) @(posedge clk);
        #2;
        // R2 reset state
        check("R2", 129'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // R4 halfword into top lane of 8H
        run_op(3'd1, 3'd3, 4'd7, 4'd0, '0, 64'h1234_5678_9ABC_F124, pat, "R4");
        check("R4", {1'b0, 16'hF124, pat[111:0]});
        // R6 word broadcast from lane 2 of 4S
        run_op(3'd3, 3'd5, 4'd0, 4'd2, v10, '0, '1, "R6");
        check("R6", {1'b0, {4{32'h3344AABB}}});
        // R7 64-bit form broadcast clears upper half
        run_op(3'd4, 3'd4, 4'd0, 4'd0, '0, 64'hFFFF_FFFF_DEAD_BEEF, '1, "R7");
        check("R7", {1'b0, 64'd0, {2{32'hDEADBEEF}}});
        // R5 wide scalar insert keeps upper, then rejected on 2D
        run_op(3'd2, 3'd6, 4'd0, 4'd0, '0, 64'h0123_4567_89AB_CDEF, pat, "R5");
        run_op(3'd2, 3'd7, 4'd0, 4'd0, '0, 64'h0123_4567_89AB_CDEF, pat, "R5");
        // R8 wide scalar broadcast on 2D, rejected on 1D and 4S
        run_op(3'd5, 3'd7, 4'd0, 4'd0, '0, 64'hA5A5_0000_1111_2222, pat, "R8");
        run_op(3'd5, 3'd6, 4'd0, 4'd0, '0, 64'hA5A5_0000_1111_2222, pat, "R8");
        run_op(3'd5, 3'd5, 4'd0, 4'd0, '0, 64'hA5A5_0000_1111_2222, pat, "R8");
        // R4 narrow scalar on doubleword configs is rejected
        run_op(3'd1, 3'd7, 4'd0, 4'd0, '0, 64'h77, pat, "R4");
        // R10 reserved opcodes
        run_op(3'd6, 3'd1, 4'd0, 4'd0, v10, 64'h1, pat, "R10");
        run_op(3'd7, 3'd5, 4'd1, 4'd1, v10, 64'h1, pat, "R10");
        // R3 byte lane 15 from lane 0 in 16B
        run_op(3'd0, 3'd1, 4'd15, 4'd0, {120'd0, 8'h5C}, '0, pat, "R3");
        check("R3", {1'b0, 8'h5C, pat[119:0]});
        // R1 lane layout: byte lane 3 of 8B sits at bits 31:24
        run_op(3'd0, 3'd0, 4'd3, 4'd6, {64'd0, 8'h00, 8'hC3, 48'd0}, '0, '0, "R1");
        check("R1", {1'b0, 96'd0, 8'hC3, 24'd0});
        // R9 index equal to lane count
        run_op(3'd0, 3'd0, 4'd8, 4'd0, v10, '0, pat, "R9");
        run_op(3'd3, 3'd4, 4'd0, 4'd2, v10, '0, pat, "R9");
        run_op(3'd1, 3'd3, 4'd8, 4'd0, v10, 64'h9, pat, "R9");
        run_op(3'd2, 3'd6, 4'd1, 4'd0, v10, 64'h9, pat, "R9");

        void'($urandom(32'd2024));
        for (int i = 0; i < 800; i++) begin
            logic [2:0] op;
            logic [2:0] cfg;
            logic [3:0] di;
            logic [3:0] si;
            int n;
            op  = 3'($urandom % 8);
            cfg = 3'($urandom % 8);
            n   = lanes_of(cfg);
            di  = ($urandom % 8 == 0) ? 4'($urandom) : 4'($urandom % n);
            si  = ($urandom % 8 == 0) ? 4'($urandom) : 4'($urandom % n);
            run_op(op, cfg, di, si,
                   {$urandom, $urandom, $urandom, $urandom},
                   {$urandom, $urandom},
                   {$urandom, $urandom, $urandom, $urandom}, "");
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule